// File: doc/BRIEF.md
# Split-Path Bang-Bang Clock Recovery Loop Filter

This block is the digital loop filter that sits between a bang-bang phase detector and the two current-steering DACs of a digitally tuned oscillator. It runs on the bit clock. Every cycle it receives one ternary phase decision on two wires: early, late, or no information. Along the proportional path that decision goes straight out to the proportional DAC controls in the same cycle, with no register in between. This keeps the dominant loop term as fast as possible.

The integral path collects the decisions in groups of four consecutive bits and reduces each group to one ternary vote by majority. It adds that vote into a saturating 14-bit signed accumulator once per group, so it runs at a quarter of the bit rate. The top 11 bits of the accumulator go to a second-order error-feedback delta-sigma modulator. The modulator turns them into a three-level stream that drives the integral DAC. Each step of that stream is far smaller in phase than a proportional step, so the loop stays heavily overdamped.

Top module: `cdr_split_filter`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it rises, `int_up`, `int_dn`, `int_valid` and `acc_out` are all zero, and the modulator's error state is cleared.
- R2: `prop_up` and `prop_dn` follow the decision of the current cycle with no clock delay. An early decision gives `prop_up`=1 and `prop_dn`=0. A late decision gives `prop_dn`=1 and `prop_up`=0. No decision gives both at 0.
- R3: The decision is decoded as follows. `pd_early`=1 with `pd_late`=0 means +1 (early). `pd_late`=1 with `pd_early`=0 means -1 (late). Both low, or both high, means 0, and a cycle with both high has no effect on either path.
- R4: The bit cycles are grouped in fours, starting from the first clock edge after reset is released. The vote of a group is +1 if the sum of its four decisions is positive, -1 if the sum is negative, and 0 if the sum is zero.
- R5: On the clock edge that takes the fourth decision of a group, the group's vote is added to the accumulator. `acc_out` shows the new value from that edge on. At no other edge does it change.
- R6: The accumulator saturates: it holds at +8191 and at -8192 and never wraps.
- R7: On the same edge, the modulator forms v = x + 2*e1 - e2, where x is the accumulator value before the update shifted arithmetically right by 3 (its 11 MSBs). The output is +1 when v >= 512, -1 when v < -512, and 0 otherwise. The new error e = v - 1024*output is clamped to [-1024, 1024]. Then e2 takes the old e1, and e1 takes e. The output appears as `int_up` (+1) or `int_dn` (-1).
- R8: `int_valid` is high for exactly the one cycle after each group-closing edge, and low otherwise. `int_up` and `int_dn` change only at group-closing edges.
- R9: `int_up` and `int_dn` are never high together, and `prop_up` and `prop_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_early | input | 1 | Phase decision: clock early |
| pd_late | input | 1 | Phase decision: clock late |
| prop_up | output | 1 | Proportional DAC step up (combinational) |
| prop_dn | output | 1 | Proportional DAC step down (combinational) |
| int_up | output | 1 | Integral DAC step up (modulator +1) |
| int_dn | output | 1 | Integral DAC step down (modulator -1) |
| int_valid | output | 1 | High in the cycle after each integral update |
| acc_out | output | 14 | Signed integral accumulator word |

## Verification
The proportional outputs are due in the same cycle as the decision, so the bench drives each decision at a falling edge and reads `prop_up` and `prop_dn` one time step later, before any clock edge. The integral results are due after the edge that takes the fourth decision of a group. The bench therefore reads `acc_out`, `int_up`, `int_dn` and `int_valid` at the falling edge that follows that edge, and checks that `int_valid` is low at the falling edge after the first decision of the next group. Groups are sent back to back from the release of reset, so the bench's grouping always lines up with the block's own.

// File: rtl/cdr_split_filter.sv
module cdr_split_filter #(
  parameter int ACC_W = 14,
  parameter int DSM_W = 11,
  parameter int GRP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_early,
  input  logic             pd_late,
  output logic             prop_up,
  output logic             prop_dn,
  output logic             int_up,
  output logic             int_dn,
  output logic             int_valid,
  output logic [ACC_W-1:0] acc_out
);
  localparam int CW = $clog2(GRP);
  localparam int SW = $clog2(GRP) + 2;
  localparam int VW = DSM_W + 3;
  localparam int EW = DSM_W + 1;
  localparam logic signed [VW-1:0] LVL  = VW'(2 ** (DSM_W - 1));
  localparam logic signed [VW-1:0] HALF = VW'(2 ** (DSM_W - 2));

  logic signed [1:0]       dec, vote;
  logic [CW-1:0]           phase_q;
  logic signed [SW-1:0]    sum_q, tot;
  logic                    last;
  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic signed [ACC_W:0]   acc_sum;
  logic signed [EW-1:0]    e1_q, e2_q, e_c;
  logic signed [DSM_W-1:0] x;
  logic signed [VW-1:0]    v, e_raw;
  logic                    qp, qn;

  assign prop_up = pd_early & ~pd_late;
  assign prop_dn = pd_late & ~pd_early;
  assign dec     = prop_up ? 2'sd1 : (prop_dn ? -2'sd1 : 2'sd0);

  assign last = (phase_q == CW'(GRP - 1));
  assign tot  = sum_q + SW'(dec);
  assign vote = (tot > 0) ? 2'sd1 : ((tot < 0) ? -2'sd1 : 2'sd0);

  assign acc_sum = {acc_q[ACC_W-1], acc_q} + (ACC_W+1)'(vote);
  assign acc_nx  = (acc_sum[ACC_W] != acc_sum[ACC_W-1])
                 ? {acc_sum[ACC_W], {(ACC_W-1){~acc_sum[ACC_W]}}}
                 : acc_sum[ACC_W-1:0];

  assign x     = acc_q[ACC_W-1 -: DSM_W];
  assign v     = VW'(x) + (VW'(e1_q) <<< 1) - VW'(e2_q);
  assign qp    = (v >= HALF);
  assign qn    = (v < -HALF);
  assign e_raw = v - (qp ? LVL : (qn ? -LVL : '0));
  assign e_c   = (e_raw > LVL) ? EW'(LVL) : ((e_raw < -LVL) ? EW'(-LVL) : EW'(e_raw));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= '0;
      sum_q     <= '0;
      acc_q     <= '0;
      e1_q      <= '0;
      e2_q      <= '0;
      int_up    <= 1'b0;
      int_dn    <= 1'b0;
      int_valid <= 1'b0;
    end else begin
      phase_q   <= last ? '0 : phase_q + 1'b1;
      sum_q     <= last ? '0 : tot;
      int_valid <= last;
      if (last) begin
        acc_q  <= acc_nx;
        int_up <= qp;
        int_dn <= qn;
        e1_q   <= e_c;
        e2_q   <= e1_q;
      end
    end
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/cdr_split_filter_chk.sv
module cdr_split_filter_chk #(
  parameter int ACC_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prop_up,
  input logic             prop_dn,
  input logic             int_up,
  input logic             int_dn,
  input logic             int_valid,
  input logic [ACC_W-1:0] acc_out
);
  p_prop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(prop_up && prop_dn));

  p_int_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_up && int_dn));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |=> !int_valid);

  p_int_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_valid |-> $stable({int_up, int_dn}));

  p_acc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !int_valid |-> $stable(acc_out));

  p_acc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_valid |-> (acc_out == $past(acc_out)) ||
                  (acc_out == $past(acc_out) + 1'b1) ||
                  (acc_out == $past(acc_out) - 1'b1));
endmodule

bind cdr_split_filter cdr_split_filter_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prop_up(prop_up), .prop_dn(prop_dn),
  .int_up(int_up), .int_dn(int_dn), .int_valid(int_valid), .acc_out(acc_out)
);

// File: tb/cdr_split_filter_test.sv
module cdr_split_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_early = 1'b0;
  logic        pd_late = 1'b0;
  logic        prop_up, prop_dn, int_up, int_dn, int_valid;
  logic [13:0] acc_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_acc, m_e1, m_e2;

  // each entry: four decisions {late,early} first-to-last, then expected vote code (01=+1, 11=-1, 00=0)
  localparam logic [9:0] VEC [10] = '{
    {2'b01, 2'b01, 2'b01, 2'b01, 2'b01},
    {2'b10, 2'b10, 2'b10, 2'b10, 2'b11},
    {2'b01, 2'b10, 2'b01, 2'b10, 2'b00},
    {2'b01, 2'b00, 2'b00, 2'b00, 2'b01},
    {2'b00, 2'b10, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b11, 2'b11, 2'b11, 2'b00},
    {2'b01, 2'b01, 2'b10, 2'b00, 2'b01},
    {2'b10, 2'b10, 2'b01, 2'b11, 2'b11},
    {2'b00, 2'b00, 2'b00, 2'b00, 2'b00},
    {2'b01, 2'b10, 2'b10, 2'b01, 2'b00}
  };

  cdr_split_filter uut (
    .clk(clk), .rst_n(rst_n), .pd_early(pd_early), .pd_late(pd_late),
    .prop_up(prop_up), .prop_dn(prop_dn), .int_up(int_up), .int_dn(int_dn),
    .int_valid(int_valid), .acc_out(acc_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pd_early = 1'b0; pd_late = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(acc_out == 14'd0, "R1 acc", int'(acc_out), 0);
    check({int_up, int_dn, int_valid} == 3'b000, "R1 int", int'({int_up, int_dn, int_valid}), 0);
    rst_n = 1'b1;
    m_acc = 0; m_e1 = 0; m_e2 = 0;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bit_cycle(input logic [1:0] d);
    pd_early = d[0];
    pd_late  = d[1];
    #1;
    check(prop_up == (d == 2'b01), "R2 prop_up", int'(prop_up), int'(d == 2'b01));
    check(prop_dn == (d == 2'b10), "R2/R3 prop_dn", int'(prop_dn), int'(d == 2'b10));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic group(input logic [7:0] ds, input int vote);
    int x, v, y, e;
    for (int i = 0; i < 4; i++) begin
      bit_cycle(ds[7-2*i -: 2]);
      if (i == 0) check(int_valid == 1'b0, "R8 valid low mid-group", int'(int_valid), 0);
    end
    x = m_acc >>> 3;
    v = x + 2 * m_e1 - m_e2;
    y = (v >= 512) ? 1 : ((v < -512) ? -1 : 0);
    e = v - 1024 * y;
    if (e > 1024) e = 1024;
    if (e < -1024) e = -1024;
    m_e2 = m_e1; m_e1 = e;
    m_acc = m_acc + vote;
    if (m_acc > 8191) m_acc = 8191;
    if (m_acc < -8192) m_acc = -8192;
    check($signed(acc_out) == m_acc, "R4/R5 acc", int'($signed(acc_out)), m_acc);
    check(int_valid == 1'b1, "R8 valid", int'(int_valid), 1);
    check(int'(int_up) - int'(int_dn) == y, "R7 dsm", int'(int_up) - int'(int_dn), y);
  endtask

  initial begin
    do_reset();
    // R4 table walk (votes include R3 both-high groups)
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 10; k++)
        group(VEC[k][9:2], (VEC[k][1:0] == 2'b01) ? 1 : ((VEC[k][1:0] == 2'b11) ? -1 : 0));
    // R1: reset mid-run clears the accumulator
    do_reset();
    group(8'b00_00_00_00, 0);
    check(acc_out == 14'd0, "R1 after reset", int'(acc_out), 0);
    // R6: positive saturation, then negative saturation; R7 tracked throughout
    for (int g = 0; g < 8200; g++) group(8'b01_01_01_01, 1);
    check($signed(acc_out) == 8191, "R6 max", int'($signed(acc_out)), 8191);
    for (int g = 0; g < 16400; g++) group(8'b10_10_00_10, -1);
    check($signed(acc_out) == -8192, "R6 min", int'($signed(acc_out)), -8192);
    group(8'b01_00_00_00, 1);
    check($signed(acc_out) == -8191, "R6 leave min", int'($signed(acc_out)), -8191);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule